// File: doc/BRIEF.md
# Fuse Calibration Reader

This block fetches a factory calibration record from a one-time-programmable fuse array and turns it into two 16-bit reference readings. A single `start` pulse launches the sequence. The block drives the fuse controller's small register port one byte at a time. Each byte goes through a fixed handshake: wait until ready, clear done, load the address, issue the read, wait until ready, clear done, capture the data, then scrub the data register. Eight coded bytes are fetched from consecutive addresses.

Each coded byte carries one data nibble in its low half and four parity bits in its high half. The eight nibbles form a 32-bit word. The low half of that word is the low-voltage reference reading and the high half is the high-voltage reference reading. A single bad parity bit anywhere rejects the whole record. A fuse controller that stays busy too long ends the sequence with a timeout.

Top module: `fcal_reader`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `calValid`, `parityErr` and `timeoutErr` are 0, both result words are 0, and no bus read or write is issued.
- R2: The fuse register select uses these codes: 0 = status, 1 = address, 2 = data, 3 = command. Status bit 0 is ready and status bit 1 is read-done, which is cleared by writing 1 to it. For each byte the block issues exactly these writes and data reads, in this order: write status = 2, write address, write command = 2, write status = 2, read data, write data = `CLEAN_VAL`. Before the first status write the block polls status until bit 0 is 1. Before the second status write it polls again. Polling consists of status reads only.
- R3: The byte addresses written are `BASE_ADDR` through `BASE_ADDR+7`, in ascending order, one per byte.
- R4: Coded byte k (k = 0..7, in fetch order) supplies bits 4k+3..4k of a 32-bit word through its bits 3:0. On success, `calLow` is word bits 15:0, `calHigh` is word bits 31:16, and `calValid` is 1.
- R5: A coded byte with nibble n is correct when bit 4 = n0^n1, bit 5 = n2^n3, bit 6 = n0^n2 and bit 7 = n1^n3. If any of the eight bytes fails this check, the block sets `parityErr`, leaves `calValid` at 0 and leaves both words at 0.
- R6: A ready wait that sees ready low on `TIMEOUT_CYC` consecutive polls ends the sequence. The block sets `timeoutErr` and issues no further bus operation. A wait that sees `TIMEOUT_CYC-1` not-ready polls continues normally.
- R7: `start` clears every result output and raises `busy`. The sequence ends with a one-cycle `done` pulse, and in that same cycle the final flags and words are visible and `busy` is 0.
- R8: A `start` pulse while `busy` is 1 is ignored. The running sequence completes unchanged, and no extra bus operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a calibration fetch |
| busSel | output | 2 | Fuse register select (0 status, 1 address, 2 data, 3 command) |
| busWr | output | 1 | Register write strobe |
| busRd | output | 1 | Register read strobe |
| busWData | output | ADDR_W | Write data |
| busRData | input | ADDR_W | Read data of the selected register, combinational |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| calValid | output | 1 | Calibration words are valid |
| parityErr | output | 1 | A coded byte failed its parity check |
| timeoutErr | output | 1 | A ready wait exceeded the limit |
| calLow | output | 16 | Low-voltage reference reading |
| calHigh | output | 16 | High-voltage reference reading |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 12 and the default base address 24 and clean value 2. The small limit lets one fuse model with adjustable read latency cover three cases in a few hundred cycles: a read that ends just inside the limit (11 busy polls), one that hits it exactly (12 polls), and a controller that is never ready at all. The default address base keeps the expected byte addresses at 24..31, where the bench loads coded words that have both correct and deliberately broken parity.

// File: rtl/fcal_pkg.sv
package fcal_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_ADDR   = 2'd1,
    REG_DATA   = 2'd2,
    REG_CMD    = 2'd3
  } regSel_t;

  typedef enum logic [1:0] {
    WD_DONECLR,
    WD_ADDR,
    WD_CMD,
    WD_CLEAN
  } wdSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic   clrTimer;
    logic   tickTimer;
    logic   clrIdx;
    logic   incIdx;
    logic   capture;
    logic   clearOut;
    logic   setValid;
    logic   setParity;
    logic   setTimeout;
    wdSel_t wdSel;
  } ctl_t;

  localparam int READY_BIT = 0;
  localparam int DONE_BIT  = 1;
  localparam int RDCMD_BIT = 1;
  localparam int CAL_W     = 16;
  localparam int NUM_BYTES = 2 * CAL_W / 4;
endpackage

// File: rtl/fcal_ctrl.sv
module fcal_ctrl
  import fcal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       ready,
  input  logic       timerHit,
  input  logic       idxLast,
  input  logic       parityOk,
  output ctl_t       ctl,
  output logic [1:0] busSel,
  output logic       busWr,
  output logic       busRd,
  output logic       busy
);
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_PRE, S_CLR_PRE, S_LOAD_ADDR, S_ISSUE,
    S_WAIT_POST, S_CLR_POST, S_CAPTURE, S_SCRUB, S_FINISH
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.wdSel = WD_DONECLR;
    busSel    = REG_STATUS;
    busWr     = 1'b0;
    busRd     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.clearOut = 1'b1;
          ctl.clrIdx   = 1'b1;
          ctl.clrTimer = 1'b1;
          nextState    = S_WAIT_PRE;
        end
      end
      S_WAIT_PRE, S_WAIT_POST: begin
        busRd = 1'b1;
        if (ready) begin
          nextState = (state == S_WAIT_PRE) ? S_CLR_PRE : S_CLR_POST;
        end else if (timerHit) begin
          ctl.setTimeout = 1'b1;
          nextState      = S_IDLE;
        end else begin
          ctl.tickTimer = 1'b1;
        end
      end
      S_CLR_PRE, S_CLR_POST: begin
        busWr     = 1'b1;
        ctl.wdSel = WD_DONECLR;
        nextState = (state == S_CLR_PRE) ? S_LOAD_ADDR : S_CAPTURE;
      end
      S_LOAD_ADDR: begin
        busSel    = REG_ADDR;
        busWr     = 1'b1;
        ctl.wdSel = WD_ADDR;
        nextState = S_ISSUE;
      end
      S_ISSUE: begin
        busSel       = REG_CMD;
        busWr        = 1'b1;
        ctl.wdSel    = WD_CMD;
        ctl.clrTimer = 1'b1;
        nextState    = S_WAIT_POST;
      end
      S_CAPTURE: begin
        busSel      = REG_DATA;
        busRd       = 1'b1;
        ctl.capture = 1'b1;
        nextState   = S_SCRUB;
      end
      S_SCRUB: begin
        busSel    = REG_DATA;
        busWr     = 1'b1;
        ctl.wdSel = WD_CLEAN;
        if (idxLast) begin
          nextState = S_FINISH;
        end else begin
          ctl.incIdx   = 1'b1;
          ctl.clrTimer = 1'b1;
          nextState    = S_WAIT_PRE;
        end
      end
      S_FINISH: begin
        if (parityOk) ctl.setValid  = 1'b1;
        else          ctl.setParity = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/fcal_dp.sv
module fcal_dp
  import fcal_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BASE_ADDR   = 24,
  parameter int TIMEOUT_CYC = 1000,
  parameter int CLEAN_VAL   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] busRData,
  output logic [ADDR_W-1:0] busWData,
  output logic              timerHit,
  output logic              idxLast,
  output logic              parityOk,
  output logic              done,
  output logic              calValid,
  output logic              parityErr,
  output logic              timeoutErr,
  output logic [CAL_W-1:0]  calLow,
  output logic [CAL_W-1:0]  calHigh
);
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  logic [IDX_W-1:0]       idx;
  logic [TMR_W-1:0]       timer;
  logic [7:0]             codeByte [NUM_BYTES];
  logic [NUM_BYTES-1:0]   byteOk;
  logic [4*NUM_BYTES-1:0] nibbles;

  assign timerHit = (timer == TMR_W'(TIMEOUT_CYC - 1));
  assign idxLast  = (idx == IDX_W'(NUM_BYTES - 1));

  always_comb begin
    unique case (ctl.wdSel)
      WD_DONECLR: busWData = ADDR_W'(1) << DONE_BIT;
      WD_ADDR:    busWData = ADDR_W'(BASE_ADDR) + ADDR_W'(idx);
      WD_CMD:     busWData = ADDR_W'(1) << RDCMD_BIT;
      default:    busWData = ADDR_W'(CLEAN_VAL);
    endcase
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    assign nibbles[4*g +: 4] = codeByte[g][3:0];
    assign byteOk[g] = (codeByte[g][7:4] ==
                        {codeByte[g][1] ^ codeByte[g][3],
                         codeByte[g][0] ^ codeByte[g][2],
                         codeByte[g][2] ^ codeByte[g][3],
                         codeByte[g][0] ^ codeByte[g][1]});
  end
  assign parityOk = &byteOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx   <= '0;
      timer <= '0;
      for (int i = 0; i < NUM_BYTES; i++) codeByte[i] <= '0;
    end else begin
      if (ctl.clrIdx)      idx <= '0;
      else if (ctl.incIdx) idx <= idx + 1'b1;
      if (ctl.clrTimer)       timer <= '0;
      else if (ctl.tickTimer) timer <= timer + 1'b1;
      if (ctl.capture) codeByte[idx] <= busRData[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done       <= 1'b0;
      calValid   <= 1'b0;
      parityErr  <= 1'b0;
      timeoutErr <= 1'b0;
      calLow     <= '0;
      calHigh    <= '0;
    end else begin
      done <= ctl.setValid | ctl.setParity | ctl.setTimeout;
      if (ctl.clearOut) begin
        calValid   <= 1'b0;
        parityErr  <= 1'b0;
        timeoutErr <= 1'b0;
        calLow     <= '0;
        calHigh    <= '0;
      end
      if (ctl.setValid) begin
        calValid <= 1'b1;
        calLow   <= nibbles[CAL_W-1:0];
        calHigh  <= nibbles[2*CAL_W-1:CAL_W];
      end
      if (ctl.setParity)  parityErr  <= 1'b1;
      if (ctl.setTimeout) timeoutErr <= 1'b1;
    end
  end
endmodule

// File: rtl/fcal_reader.sv
module fcal_reader
  import fcal_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BASE_ADDR   = 24,
  parameter int TIMEOUT_CYC = 1000,
  parameter int CLEAN_VAL   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [1:0]        busSel,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busWData,
  input  logic [ADDR_W-1:0] busRData,
  output logic              busy,
  output logic              done,
  output logic              calValid,
  output logic              parityErr,
  output logic              timeoutErr,
  output logic [15:0]       calLow,
  output logic [15:0]       calHigh
);
  ctl_t ctl;
  logic timerHit, idxLast, parityOk;

  fcal_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ready    (busRData[READY_BIT]),
    .timerHit (timerHit),
    .idxLast  (idxLast),
    .parityOk (parityOk),
    .ctl      (ctl),
    .busSel   (busSel),
    .busWr    (busWr),
    .busRd    (busRd),
    .busy     (busy)
  );

  fcal_dp #(
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CLEAN_VAL   (CLEAN_VAL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busRData   (busRData),
    .busWData   (busWData),
    .timerHit   (timerHit),
    .idxLast    (idxLast),
    .parityOk   (parityOk),
    .done       (done),
    .calValid   (calValid),
    .parityErr  (parityErr),
    .timeoutErr (timeoutErr),
    .calLow     (calLow),
    .calHigh    (calHigh)
  );
endmodule

// File: rtl/fcal_checker.sv
module fcal_checker #(
  parameter int ADDR_W    = 10,
  parameter int BASE_ADDR = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busSel,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busWData,
  input logic              busy,
  input logic              done,
  input logic              calValid,
  input logic              parityErr,
  input logic              timeoutErr
);
  // R2: never a read and a write in the same cycle
  a_r2_one_op: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));

  // R2: a read command directly follows the address load
  a_r2_cmd_after_addr: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd3) |-> $past(busWr && busSel == 2'd1));

  // R2: data is captured only right after read-done was cleared
  a_r2_capture_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busSel == 2'd2) |-> $past(busWr && busSel == 2'd0 && busWData == ADDR_W'(2)));

  // R3: every address stays inside the calibration window
  a_r3_addr_window: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd1) |->
      (busWData >= ADDR_W'(BASE_ADDR) && busWData <= ADDR_W'(BASE_ADDR + 7)));

  // R5: valid and an error flag never coexist
  a_r5_valid_xor_err: assert property (@(posedge clk) disable iff (!rstN)
    !(calValid && (parityErr || timeoutErr)));

  // R6: after a timeout the bus stays silent until a new run
  a_r6_silent_after_timeout: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutErr && !busy) |-> (!busWr && !busRd));

  // R7: results are cleared for the whole run
  a_r7_clear_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!calValid && !parityErr && !timeoutErr));

  // R7: done is a single-cycle pulse seen while idle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind fcal_reader fcal_checker #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_fcal_checker (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busRd      (busRd),
  .busWData   (busWData),
  .busy       (busy),
  .done       (done),
  .calValid   (calValid),
  .parityErr  (parityErr),
  .timeoutErr (timeoutErr)
);

// File: tb/test_fcal_reader.sv
module test_fcal_reader;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int BASE       = 24;
  localparam int LIMIT      = 12;
  localparam int CLEAN      = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        busSel;
  logic              busWr, busRd;
  logic [ADDR_W-1:0] busWData, busRData;
  logic              busy, done, calValid, parityErr, timeoutErr;
  logic [15:0]       calLow, calHigh;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcal_reader #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .TIMEOUT_CYC(LIMIT), .CLEAN_VAL(CLEAN)
  ) i_fcal_reader (
    .clk(clk), .rstN(rstN), .start(start),
    .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWData(busWData), .busRData(busRData),
    .busy(busy), .done(done), .calValid(calValid),
    .parityErr(parityErr), .timeoutErr(timeoutErr),
    .calLow(calLow), .calHigh(calHigh)
  );

  // fuse controller model
  logic [7:0]        mem [0:1023];
  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        dataReg;
  logic              doneBit;
  logic [7:0]        busyCnt;
  logic [7:0]        lat = 8'd3;
  logic              forceBusy = 1'b0;
  wire               fuseReady = (busyCnt == 0) && !forceBusy;

  always_comb begin
    case (busSel)
      2'd0:    busRData = {{(ADDR_W-2){1'b0}}, doneBit, fuseReady};
      2'd1:    busRData = addrReg;
      2'd2:    busRData = {{(ADDR_W-8){1'b0}}, dataReg};
      default: busRData = '0;
    endcase
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0; dataReg <= '0; doneBit <= 1'b0; busyCnt <= '0;
    end else begin
      if (busyCnt != 0) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == 1) begin
          dataReg <= mem[addrReg];
          doneBit <= 1'b1;
        end
      end
      if (busWr) begin
        case (busSel)
          2'd0: if (busWData[1]) doneBit <= 1'b0;
          2'd1: addrReg <= busWData;
          2'd2: dataReg <= busWData[7:0];
          default: if (busWData[1]) busyCnt <= (lat == 0) ? 8'd1 : lat;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard of bus operations: {wr, sel, value}
  logic [12:0] expQ [$];

  function automatic logic [12:0] mkOp(input bit wr, input logic [1:0] sel, input int val);
    return {wr, sel, ADDR_W'(val)};
  endfunction

  task automatic pushByte(input int k, input bit full);
    expQ.push_back(mkOp(1, 2'd0, 2));
    expQ.push_back(mkOp(1, 2'd1, BASE + k));
    expQ.push_back(mkOp(1, 2'd3, 2));
    if (full) begin
      expQ.push_back(mkOp(1, 2'd0, 2));
      expQ.push_back(mkOp(0, 2'd2, 0));
      expQ.push_back(mkOp(1, 2'd2, CLEAN));
    end
  endtask

  task automatic pushAll();
    for (int k = 0; k < 8; k++) pushByte(k, 1'b1);
  endtask

  always @(negedge clk) begin
    if (rstN && (busWr || (busRd && busSel == 2'd2))) begin
      logic [12:0] got;
      got = {busWr, busSel, busWr ? busWData : '0};
      if (expQ.size() == 0) begin
        check(1'b0, "R2 R3 R8 unexpected bus op", got, 0);
      end else begin
        logic [12:0] want;
        want = expQ.pop_front();
        check(got == want, "R2 R3 bus op order", got, want);
      end
    end
  end

  function automatic logic [7:0] enc(input logic [3:0] n);
    return {n[1]^n[3], n[0]^n[2], n[2]^n[3], n[0]^n[1], n};
  endfunction

  task automatic loadWord(input logic [31:0] w);
    for (int k = 0; k < 8; k++) mem[BASE + k] = enc(w[4*k +: 4]);
  endtask

  task automatic runOnce(input bit extraStart);
    int n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1 && !calValid && !parityErr && !timeoutErr && calLow == 0,
          "R7 start clears and busy", {busy, calValid, parityErr, timeoutErr}, 4'b1000);
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
      if (extraStart && n == 20) start = 1'b1;
      if (extraStart && n == 21) start = 1'b0;
    end
    check(done == 1'b1 && busy == 1'b0, "R7 done pulse while idle", {done, busy}, 2'b10);
  endtask

  task automatic expectGood(input logic [31:0] w, input string tag);
    check(calValid && !parityErr && !timeoutErr, {tag, " R4 valid"},
          {calValid, parityErr, timeoutErr}, 3'b100);
    check(calLow == w[15:0],  {tag, " R4 calLow"},  calLow,  w[15:0]);
    check(calHigh == w[31:16], {tag, " R4 calHigh"}, calHigh, w[31:16]);
    check(expQ.size() == 0, {tag, " R2 all ops seen"}, expQ.size(), 0);
    check(dataReg == CLEAN, {tag, " R2 data scrubbed"}, dataReg, CLEAN);
    @(negedge clk);
    check(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
  endtask

  task automatic expectErr(input bit par, input string tag);
    check(!calValid && parityErr == par && timeoutErr == !par && calLow == 0 && calHigh == 0,
          tag, {calValid, parityErr, timeoutErr, calLow, calHigh}, {1'b0, par, !par, 32'h0});
    check(expQ.size() == 0, {tag, " op count"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !calValid && !parityErr && !timeoutErr && calLow == 0 &&
          calHigh == 0 && !busWr && !busRd, "R1 reset state",
          {busy, done, calValid, parityErr, timeoutErr, busWr, busRd}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busWr && !busRd && !busy, "R1 idle after reset", {busWr, busRd, busy}, 0);

    // R4 good words, different latencies
    lat = 8'd3; loadWord(32'h5A3C_0F96); pushAll(); runOnce(1'b0);
    expectGood(32'h5A3C_0F96, "pattern A");
    lat = 8'd1; loadWord(32'hFFFF_0000); pushAll(); runOnce(1'b0);
    expectGood(32'hFFFF_0000, "pattern B");
    // R6: LIMIT-1 busy polls still succeed
    lat = 8'(LIMIT - 1); loadWord(32'h1234_ABCD); pushAll(); runOnce(1'b0);
    expectGood(32'h1234_ABCD, "R6 just inside limit");

    // R5 parity faults
    lat = 8'd2; loadWord(32'h8765_4321); mem[BASE + 5] ^= 8'h40; pushAll(); runOnce(1'b0);
    expectErr(1'b1, "R5 bad bit6 byte5");
    loadWord(32'h0000_0001); mem[BASE] ^= 8'h10; pushAll(); runOnce(1'b0);
    expectErr(1'b1, "R5 bad bit4 byte0");
    loadWord(32'hC3C3_3C3C); mem[BASE + 7] ^= 8'h01; pushAll(); runOnce(1'b0);
    expectErr(1'b1, "R5 bad nibble byte7");

    // R6 timeout after command
    loadWord(32'h1111_2222); lat = 8'(LIMIT); pushByte(0, 1'b0); runOnce(1'b0);
    expectErr(1'b0, "R6 timeout post wait");
    // R6 timeout before first access
    lat = 8'd2; forceBusy = 1'b1; runOnce(1'b0);
    expectErr(1'b0, "R6 timeout pre wait");
    repeat (10) @(negedge clk);
    check(expQ.size() == 0 && !busy, "R6 silent after timeout", busy, 0);
    forceBusy = 1'b0;

    // R8 start ignored while busy; also R7 clears old errors
    loadWord(32'hBEEF_CAFE); pushAll(); runOnce(1'b1);
    expectGood(32'hBEEF_CAFE, "R8 restart ignored");
    repeat (30) @(negedge clk);
    check(!busy && expQ.size() == 0, "R8 no trailing run", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule